// File: doc/BRIEF.md
# Seven-Input Threshold Thermometer

This block looks at seven single-bit inputs and raises a set of seven threshold flags. Flag k is high when k or more of the inputs are high. The flags therefore always form a thermometer code of the input population, and downstream logic can compare the population against any threshold by reading a single bit. No adder or comparator is needed.

Internally every gate is a five-input majority cell with a polarity control. The cell drives its vote result when the control is 1 and the inverse when it is 0. A three-input majority cell is made from it by tying one spare input low and the other high. That cell gives a two-input OR when its third input is tied high and a two-input AND when it is tied low. The array is a cascade of these OR/AND exchange pairs in alternating odd/even layers, so it sorts the seven bits with the ones moved toward flag 1.

A parameter adds one register stage on the flags. The register has a synchronous active-low reset.

Top module: `thr_therm7`

## Requirements
- R1: With the output register enabled (default), bit z_out[k-1] is 1 exactly when at least k bits of x_in were 1 at the preceding rising clock edge, for k = 1..7.
- R2: z_out is always a thermometer code filled from bit 0: if z_out[j] is 1 then z_out[i] is 1 for every i < j.
- R3: An all-zero x_in gives z_out = 7'h00 and an all-one x_in gives z_out = 7'h7F.
- R4: With the output register enabled, z_out changes only at a rising clock edge and reflects x_in one clock after it is applied. A change of x_in between edges leaves z_out unchanged.
- R5: When rst_n is 0 at a rising clock edge, z_out becomes 7'h00 after that edge, whatever x_in is.
- R6: The result depends only on how many inputs are 1, not on their positions. Inputs with equal population give equal z_out, and the number of 1 bits in z_out equals the number of 1 bits in x_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| x_in | input | 7 | The seven voting inputs |
| z_out | output | 7 | Threshold flags; bit k-1 is high when at least k inputs are high |

## Verification
A wrong exchange cell or a wrong polarity tie moves or drops a one somewhere in the sorted vector. On the next clock this shows at the ports as a gap in the thermometer or as a flag count that differs from the input population. The exhaustive sweep covers all 128 input patterns, so any bad cell is reached by at least one pattern. Register and reset faults show one edge after the stimulus, as a flag vector that is one cycle early, stale, or not cleared.

// File: rtl/thr_pkg.sv
// Package: shared sizes and vector type for the threshold thermometer.
// Assumes the array width stays at seven voters.
package thr_pkg;
    parameter int NUM_IN = 7;
    typedef logic [NUM_IN-1:0] thr_vec_t;
endpackage

// File: rtl/thr_maj5_cell.sv
// Five-input majority cell with a polarity control.
// The vote is 1 when three or more of a..e are 1. The output is the vote
// when pol is 1 and its inverse when pol is 0. Purely combinational.
module thr_maj5_cell (
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic d,
    input  logic e,
    input  logic pol,
    output logic y
);
    logic [2:0] ones;
    logic       vote;

    // Count the ones and compare against the majority threshold.
    always_comb begin
        ones = {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d} + {2'b00, e};
        vote = (ones >= 3'd3);
        y    = ~(vote ^ pol);
    end
endmodule

// File: rtl/thr_maj3_cell.sv
// Three-input majority cell built from one five-input cell.
// One spare input is tied low and the other high, so they cancel in the vote.
// Polarity is fixed to pass the vote through.
module thr_maj3_cell (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic y
);
    thr_maj5_cell core_i (
        .a  (a),
        .b  (b),
        .c  (c),
        .d  (1'b0),
        .e  (1'b1),
        .pol(1'b1),
        .y  (y)
    );
endmodule

// File: rtl/thr_xchg.sv
// Bit exchange pair: hi = a OR b, lo = a AND b.
// Both outputs come from three-input majority cells with the third input tied.
// The pair moves a one toward the hi side and keeps the number of ones.
module thr_xchg (
    input  logic a,
    input  logic b,
    output logic hi,
    output logic lo
);
    thr_maj3_cell or_i  (.a(a), .b(b), .c(1'b1), .y(hi));
    thr_maj3_cell and_i (.a(a), .b(b), .c(1'b0), .y(lo));
endmodule

// File: rtl/thr_therm7.sv
// Threshold thermometer top.
// Seven inputs are sorted by NUM_IN alternating odd/even layers of exchange
// pairs; ones gather at bit 0. Bit k-1 of the sorted vector is then the
// "at least k" flag. REG_OUT selects one output register stage.
// Assumes clk is free-running whenever REG_OUT is 1.
module thr_therm7
    import thr_pkg::*;
#(
    parameter int N       = NUM_IN,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] x_in,
    output logic [N-1:0] z_out
);
    localparam int LAYERS = N;

    logic [N-1:0] stg [0:LAYERS];
    logic [N-1:0] sorted;

    assign stg[0] = x_in;

    // Odd/even transposition layers: layer s pairs bits (i, i+1) with i%2 == s%2.
    for (genvar s = 0; s < LAYERS; s++) begin : g_layer
        for (genvar i = 0; i < N; i++) begin : g_bit
            if (((i % 2) == (s % 2)) && (i + 1 < N)) begin : g_pair
                thr_xchg xchg_i (
                    .a (stg[s][i]),
                    .b (stg[s][i+1]),
                    .hi(stg[s+1][i]),
                    .lo(stg[s+1][i+1])
                );
            end else if (!((i >= 1) && (((i - 1) % 2) == (s % 2)))) begin : g_pass
                assign stg[s+1][i] = stg[s][i];
            end
        end
    end

    assign sorted = stg[LAYERS];

    if (REG_OUT) begin : g_reg
        logic [N-1:0] z_q;
        logic         hist_ok;

        // Output register with synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) z_q <= '0;
            else        z_q <= sorted;
        end

        // Marks that one clean clock has passed since reset, for $past checks.
        always_ff @(posedge clk) begin
            if (!rst_n) hist_ok <= 1'b0;
            else        hist_ok <= 1'b1;
        end

        assign z_out = z_q;

        p_pop_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
            hist_ok |-> ($countones(z_out) == $countones($past(x_in))));
        p_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (x_in == {N{1'b1}}) |=> (z_out == {N{1'b1}}));
        p_clear_r5: assert property (@(posedge clk)
            !rst_n |=> (z_out == '0));
        p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            hist_ok && $stable(x_in) |=> $stable(z_out));
    end else begin : g_comb
        assign z_out = sorted;
    end

    p_thermo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((z_out & (z_out + 1'b1)) == '0));
endmodule

// File: tb/thr_therm7_tb_top.sv
module thr_therm7_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] x_in = '0;
    logic [6:0] z_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    thr_therm7 dut_i (.clk(clk), .rst_n(rst_n), .x_in(x_in), .z_out(z_out));

    function automatic int popc(input logic [6:0] v);
        int c = 0;
        for (int i = 0; i < 7; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic logic [6:0] thermo(input logic [6:0] v);
        logic [6:0] t = '0;
        for (int k = 1; k <= 7; k++) t[k-1] = (popc(v) >= k);
        return t;
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [6:0] v);
        @(negedge clk);
        x_in = v;
        @(negedge clk);
    endtask

    initial begin
        logic [6:0] prev;
        repeat (2) @(negedge clk);
        x_in = 7'h7F;
        @(negedge clk);
        check("R5 reset clears", z_out, 7'h00);
        rst_n = 1'b1;

        // R3 extremes
        apply(7'h00); check("R3 all zero", z_out, 7'h00);
        apply(7'h7F); check("R3 all one", z_out, 7'h7F);

        // R1 exhaustive sweep, R2 shape
        for (int v = 0; v < 128; v++) begin
            apply(7'(v));
            check("R1 threshold", z_out, thermo(7'(v)));
            check("R2 thermometer", z_out & (z_out + 7'd1), 7'h00);
        end

        // R6 position independence: equal populations, different positions
        apply(7'b0000011); prev = z_out;
        apply(7'b1000001); check("R6 same pop", z_out, prev);
        apply(7'b0101000); check("R6 same pop", z_out, prev);
        check("R6 flag count", 7'(popc(z_out)), 7'd2);

        // R4 latency: change between edges, output holds until the edge
        process_r4: begin
            @(negedge clk); x_in = 7'h01; @(negedge clk);
            x_in = 7'h1F; #2;
            check("R4 hold before edge", z_out, 7'h01);
            @(negedge clk);
            check("R4 update after edge", z_out, 7'h1F);
        end

        // Random stimulus with fixed seed
        void'($urandom(32'd1234));
        for (int n = 0; n < 300; n++) begin
            logic [6:0] r = 7'($urandom);
            apply(r);
            check("R1 random", z_out, thermo(r));
            check("R6 random count", 7'(popc(z_out)), 7'(popc(r)));
        end

        // R5 mid-run reset
        @(negedge clk); x_in = 7'h55; rst_n = 1'b0;
        @(negedge clk);
        check("R5 mid-run reset", z_out, 7'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", z_out, thermo(7'h55));

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule